// File: doc/BRIEF.md
# Configurable Two-Table Logic Slice

This block is a small programmable logic cell. It holds two four-input look-up tables whose sixteen-bit truth tables, together with a few mode bits per table, are shifted in serially over a one-bit configuration port. Once a complete configuration has been accepted, the first output realises any Boolean function of its four table inputs. The second output realises any function of five inputs: a select input chooses, per evaluation, between the second table (select high) and the first table (select low), so tying both table-input buses together yields an arbitrary five-input function.

Each output path owns a storage element that can act as a rising-edge flip-flop or as a latch that is transparent while the clock is high. Per-path mode bits pick the storage kind, whether set and clear act at once or only at a clock edge, whether set/clear and clock enable are active high or low, and whether the output shows the stored value or the combinational value. A small state machine (BLANK, SHIFT, RUN) governs configuration: the outputs are driven low outside RUN and the storage elements are frozen.

Top module: `lut_slice`

State machine: BLANK (after reset, or after an incomplete load) goes to SHIFT when cfg_en is seen high; RUN goes to SHIFT the same way; SHIFT goes to RUN when cfg_en drops after at least 42 bits were shifted in, and to BLANK when it drops after fewer.

## Requirements
- R1: The configuration chain is 42 bits, shifted in most significant bit first, one bit per rising clock edge while cfg_en is high. The word is {path1 field, path0 field}; each 21-bit field is, from its top bit down, {show_stored, en_low, setclr_low, setclr_at_edge, latch_kind, table[15:0]}. The block enters RUN on the first edge with cfg_en low after a complete load, and leaves RUN on any edge where cfg_en is high.
- R2: After reset, during loading, and after a load that stopped short of 42 bits, both outputs are 0.
- R3: With show_stored=0, out0 equals bit number tbl0_in of the path0 table.
- R4: With show_stored=0, out1 equals bit tbl1_in of the path1 table when wide_sel is 1 and bit tbl0_in of the path0 table when wide_sel is 0.
- R5: In flip-flop mode (latch_kind=0) with show_stored=1, the output takes the path's combinational value at the rising clock edge when the clock enable is active.
- R6: In flip-flop mode an inactive clock enable holds the stored value; en_low=1 makes clk_en active low.
- R7: In latch mode (latch_kind=1) the output follows the path value while clk is high and holds while clk is low, independent of clk_en.
- R8: With setclr_at_edge=0, set and clear change the stored value at once, without a clock edge; with setclr_at_edge=1 they act only at a rising edge and do so regardless of clk_en.
- R9: Set wins over clear when both are active; setclr_low=1 makes set_in and clr_in active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the latch gate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| tbl0_in | input | 4 | Index into the path0 table |
| tbl1_in | input | 4 | Index into the path1 table |
| wide_sel | input | 1 | Chooses the table feeding path1 |
| clk_en | input | 1 | Clock enable for flip-flop mode |
| set_in | input | 1 | Set request for both storage elements |
| clr_in | input | 1 | Clear request for both storage elements |
| out0 | output | 1 | Path0 result |
| out1 | output | 1 | Path1 (wide) result |

## Verification
The bench uses the default build: four-input tables and two paths, giving a 42-bit chain. With that size, all 32 combinations of the five inputs can be applied to each of several loaded table pairs, so every table bit and both wide-select arms are observed. Directed sequences then walk each storage option (edge versus level capture, immediate versus edge set/clear, both polarities, set-over-clear) as well as short and interrupted loads.

// File: rtl/lut_slice_pkg.sv
`timescale 1ns/1ps
package lut_slice_pkg;
    localparam int LUT_K     = 4;
    localparam int TBL_BITS  = 2 ** LUT_K;
    localparam int NUM_PATHS = 2;

    typedef struct packed {
        logic                show_stored;
        logic                en_low;
        logic                setclr_low;
        logic                setclr_at_edge;
        logic                latch_kind;
        logic [TBL_BITS-1:0] table_bits;
    } path_cfg_t;

    localparam int PATH_W = $bits(path_cfg_t);
    localparam int CFG_W  = PATH_W * NUM_PATHS;

    typedef enum logic [1:0] {
        LD_BLANK = 2'd0,
        LD_SHIFT = 2'd1,
        LD_RUN   = 2'd2
    } load_state_t;
endpackage

// File: rtl/lut_slice_loader.sv
`timescale 1ns/1ps
module lut_slice_loader
    import lut_slice_pkg::*;
#(
    parameter int CHAIN_W = CFG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_din,
    output logic [CHAIN_W-1:0] chain_q,
    output logic               run
);
    localparam int CNT_W = $clog2(CHAIN_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CHAIN_W);

    load_state_t st, st_nx;
    logic [CNT_W-1:0] bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LD_BLANK;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            LD_BLANK: if (cfg_en) st_nx = LD_SHIFT;
            LD_RUN:   if (cfg_en) st_nx = LD_SHIFT;
            LD_SHIFT: if (!cfg_en) st_nx = (bit_cnt == FULL) ? LD_RUN : LD_BLANK;
            default:  st_nx = LD_BLANK;
        endcase
    end

    // serial chain and saturating bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            bit_cnt <= '0;
        end else if (cfg_en) begin
            chain_q <= {chain_q[CHAIN_W-2:0], cfg_din};
            if (st != LD_SHIFT)      bit_cnt <= CNT_W'(1);
            else if (bit_cnt != FULL) bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        run = (st == LD_RUN);
    end
endmodule

// File: rtl/lut_slice_table.sv
`timescale 1ns/1ps
module lut_slice_table #(
    parameter int K = 4
) (
    input  logic [2**K-1:0] tbl,
    input  logic [K-1:0]    idx,
    output logic            y
);
    localparam int N = 2 ** K;

    // heap-ordered binary mux tree: node 0 is the root, leaves start at N-1
    logic [2*N-2:0] node;

    genvar gi, gd, gp;
    generate
        for (gi = 0; gi < N; gi++) begin : g_leaf
            assign node[N-1+gi] = tbl[gi];
        end
        for (gd = 0; gd < K; gd++) begin : g_lvl
            for (gp = 0; gp < 2 ** gd; gp++) begin : g_node
                localparam int I = 2 ** gd - 1 + gp;
                assign node[I] = idx[K-1-gd] ? node[2*I+2] : node[2*I+1];
            end
        end
    endgenerate

    assign y = node[0];
endmodule

// File: rtl/lut_slice_store.sv
`timescale 1ns/1ps
module lut_slice_store (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic d,
    input  logic clk_en,
    input  logic set_in,
    input  logic clr_in,
    input  logic latch_kind,
    input  logic setclr_at_edge,
    input  logic setclr_low,
    input  logic en_low,
    output logic q
);
    logic set_on, clr_on, en_on;
    logic imm_set, imm_clr;
    logic ff_q, lat_q;

    assign set_on  = set_in ^ setclr_low;
    assign clr_on  = clr_in ^ setclr_low;
    assign en_on   = clk_en ^ en_low;
    assign imm_set = run & ~setclr_at_edge & set_on;
    assign imm_clr = run & ~setclr_at_edge & clr_on & ~set_on;

    always_ff @(posedge clk or negedge rst_n or posedge imm_set or posedge imm_clr) begin
        if (!rst_n)                        ff_q <= 1'b0;
        else if (imm_set)                  ff_q <= 1'b1;
        else if (imm_clr)                  ff_q <= 1'b0;
        else if (run && !latch_kind) begin
            if (setclr_at_edge && set_on)      ff_q <= 1'b1;
            else if (setclr_at_edge && clr_on) ff_q <= 1'b0;
            else if (en_on)                    ff_q <= d;
        end
    end

    always_latch begin
        if (!rst_n)                             lat_q = 1'b0;
        else if (imm_set)                       lat_q = 1'b1;
        else if (imm_clr)                       lat_q = 1'b0;
        else if (run && latch_kind && clk) begin
            if (setclr_at_edge && set_on)       lat_q = 1'b1;
            else if (setclr_at_edge && clr_on)  lat_q = 1'b0;
            else                                lat_q = d;
        end
    end

    assign q = latch_kind ? lat_q : ff_q;
endmodule

// File: rtl/lut_slice.sv
`timescale 1ns/1ps
module lut_slice
    import lut_slice_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [LUT_K-1:0] tbl0_in,
    input  logic [LUT_K-1:0] tbl1_in,
    input  logic             wide_sel,
    input  logic             clk_en,
    input  logic             set_in,
    input  logic             clr_in,
    output logic             out0,
    output logic             out1
);
    logic [CFG_W-1:0] chain_q;
    logic             run;
    path_cfg_t        path_cfg [NUM_PATHS];
    logic [LUT_K-1:0] path_idx [NUM_PATHS];
    logic [NUM_PATHS-1:0] tbl_y, path_d, path_q, path_out;

    lut_slice_loader #(.CHAIN_W(CFG_W)) loader_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_en (cfg_en),
        .cfg_din(cfg_din),
        .chain_q(chain_q),
        .run    (run)
    );

    assign path_idx[0] = tbl0_in;
    assign path_idx[1] = tbl1_in;

    // path0 takes its own table; path1 takes the wide select between tables
    assign path_d[0] = tbl_y[0];
    assign path_d[1] = wide_sel ? tbl_y[1] : tbl_y[0];

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PATHS; gp++) begin : g_path
            assign path_cfg[gp] = chain_q[gp*PATH_W +: PATH_W];

            lut_slice_table #(.K(LUT_K)) table_i (
                .tbl(path_cfg[gp].table_bits),
                .idx(path_idx[gp]),
                .y  (tbl_y[gp])
            );

            lut_slice_store store_i (
                .clk           (clk),
                .rst_n         (rst_n),
                .run           (run),
                .d             (path_d[gp]),
                .clk_en        (clk_en),
                .set_in        (set_in),
                .clr_in        (clr_in),
                .latch_kind    (path_cfg[gp].latch_kind),
                .setclr_at_edge(path_cfg[gp].setclr_at_edge),
                .setclr_low    (path_cfg[gp].setclr_low),
                .en_low        (path_cfg[gp].en_low),
                .q             (path_q[gp])
            );

            assign path_out[gp] = run & (path_cfg[gp].show_stored ? path_q[gp] : path_d[gp]);
        end
    endgenerate

    assign out0 = path_out[0];
    assign out1 = path_out[1];
endmodule

// File: rtl/lut_slice_chk.sv
`timescale 1ns/1ps
module lut_slice_chk
    import lut_slice_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      run,
    input logic      cfg_en,
    input logic      clk_en,
    input logic      set_in,
    input logic      clr_in,
    input logic      out0,
    input logic      out1,
    input path_cfg_t c0
);
    logic edge_ff0, set0, clr0, en0;
    assign edge_ff0 = c0.show_stored & ~c0.latch_kind & c0.setclr_at_edge;
    assign set0     = set_in ^ c0.setclr_low;
    assign clr0     = clr_in ^ c0.setclr_low;
    assign en0      = clk_en ^ c0.en_low;

    p_leave_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> !run);

    p_enter_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !$past(cfg_en));

    p_blank_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!out0 && !out1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_en && edge_ff0 && !en0 && !set0 && !clr0) |=> $stable(out0));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_en && edge_ff0 && set0) |=> out0);

    p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_en && edge_ff0 && clr0 && !set0) |=> !out0);
endmodule

bind lut_slice lut_slice_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .cfg_en(cfg_en),
    .clk_en(clk_en),
    .set_in(set_in),
    .clr_in(clr_in),
    .out0  (out0),
    .out1  (out1),
    .c0    (path_cfg[0])
);

// File: tb/lut_slice_tb_top.sv
`timescale 1ns/1ps
module lut_slice_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] tbl0_in = '0, tbl1_in = '0;
    logic       wide_sel = 1'b0, clk_en = 1'b0, set_in = 1'b0, clr_in = 1'b0;
    logic       out0, out1;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    lut_slice dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .tbl0_in(tbl0_in), .tbl1_in(tbl1_in), .wide_sel(wide_sel),
        .clk_en(clk_en), .set_in(set_in), .clr_in(clr_in),
        .out0(out0), .out1(out1)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // field: {show_stored, en_low, setclr_low, setclr_at_edge, latch_kind, table}
    function automatic logic [20:0] fld(input logic so, input logic el, input logic sl,
                                        input logic se, input logic lk, input logic [15:0] t);
        return {so, el, sl, se, lk, t};
    endfunction

    task automatic shift_bits(input logic [41:0] w, input int nbits);
        for (int i = 41; i > 41 - nbits; i--) begin
            @(negedge clk); #0.5;
            cfg_en = 1'b1; cfg_din = w[i];
        end
        @(negedge clk); #0.5;
        cfg_en = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic load(input logic [20:0] p1, input logic [20:0] p0);
        shift_bits({p1, p0}, 42);
    endtask

    task automatic drv; @(negedge clk); #0.5; endtask
    task automatic hi;  @(posedge clk); #1;   endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] ta, tb;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        hi;
        check("R2 reset out0", out0, 1'b0);
        check("R2 reset out1", out1, 1'b0);

        // short load of ones: stays blank
        shift_bits({42{1'b1}}, 20);
        tbl0_in = 4'd3;
        #0.5 check("R2 short load out0", out0, 1'b0);

        // full load, then interrupt mid-stream
        load(fld(0,0,0,1,0,16'hFFFF), fld(0,0,0,1,0,16'hFFFF));
        check("R1 full load out0", out0, 1'b1);
        drv; cfg_en = 1'b1; cfg_din = 1'b0;
        hi;
        check("R1 loading out0", out0, 1'b0);
        drv; cfg_en = 1'b0;
        hi;
        check("R2 interrupted out1", out1, 1'b0);

        // exhaustive combinational sweeps, R3 and R4
        for (int s = 0; s < 6; s++) begin
            case (s)
                0: begin ta = 16'h0000; tb = 16'hFFFF; end
                1: begin ta = 16'hAAAA; tb = 16'h00FF; end
                2: begin ta = 16'h8001; tb = 16'h1248; end
                default: begin ta = 16'($urandom); tb = 16'($urandom); end
            endcase
            load(fld(0,0,0,1,0,tb), fld(0,0,0,1,0,ta));
            for (int v = 0; v < 32; v++) begin
                tbl0_in = 4'(v); tbl1_in = 4'(v); wide_sel = v[4];
                #0.2;
                check("R3 table0", out0, ta[v[3:0]]);
                check("R4 wide", out1, v[4] ? tb[v[3:0]] : ta[v[3:0]]);
            end
        end
        // split indices for R4
        tbl0_in = 4'd2; tbl1_in = 4'd9; wide_sel = 1'b1; #0.2;
        check("R4 split sel1", out1, tb[9]);
        wide_sel = 1'b0; #0.2;
        check("R4 split sel0", out1, ta[2]);

        // flip-flop, edge set/clear
        drv; clk_en = 1'b1; set_in = 0; clr_in = 0; wide_sel = 0;
        load(fld(0,0,0,1,0,16'h0000), fld(1,0,0,1,0,16'hAAAA));
        drv; tbl0_in = 4'd1; hi;
        check("R5 capture 1", out0, 1'b1);
        drv; tbl0_in = 4'd0; hi;
        check("R5 capture 0", out0, 1'b0);
        drv; clk_en = 1'b0; tbl0_in = 4'd1; hi;
        check("R6 hold", out0, 1'b0);
        drv; tbl0_in = 4'd0; set_in = 1'b1; #1;
        check("R8 edge set waits", out0, 1'b0);
        hi;
        check("R8 edge set", out0, 1'b1);
        drv; clr_in = 1'b1; hi;
        check("R9 set wins edge", out0, 1'b1);
        drv; set_in = 1'b0; hi;
        check("R8 edge clear", out0, 1'b0);

        // flip-flop, immediate set/clear
        drv; clr_in = 1'b0;
        load(fld(0,0,0,1,0,16'h0000), fld(1,0,0,0,0,16'hAAAA));
        drv; set_in = 1'b1; #1;
        check("R8 immediate set", out0, 1'b1);
        drv; set_in = 1'b0; clk_en = 1'b1; tbl0_in = 4'd0; hi;
        check("R5 after set", out0, 1'b0);
        drv; set_in = 1'b1; clr_in = 1'b1; #1;
        check("R9 set wins immediate", out0, 1'b1);
        drv; set_in = 1'b0; clr_in = 1'b0;

        // inverted polarities
        drv; set_in = 1'b1; clr_in = 1'b1; clk_en = 1'b1;
        load(fld(0,0,0,1,0,16'h0000), fld(1,1,1,1,0,16'hAAAA));
        drv; tbl0_in = 4'd0; hi;
        check("R6 low enable inactive", out0, 1'b1);
        drv; clk_en = 1'b0; hi;
        check("R6 low enable active", out0, 1'b0);
        drv; set_in = 1'b0; hi;
        check("R9 low set", out0, 1'b1);
        drv; set_in = 1'b1; clr_in = 1'b0; hi;
        check("R9 low clear", out0, 1'b0);

        // latch on path1
        drv; set_in = 1'b0; clr_in = 1'b0; clk_en = 1'b0; wide_sel = 1'b1; tbl1_in = 4'd0;
        load(fld(1,0,0,1,1,16'hAAAA), fld(0,0,0,1,0,16'h0000));
        drv; tbl1_in = 4'd1; #1;
        check("R7 closed holds", out1, 1'b0);
        hi;
        check("R7 open follows", out1, 1'b1);
        drv; tbl1_in = 4'd0; #1;
        check("R7 closed keeps", out1, 1'b1);
        hi;
        check("R7 open follows 0", out1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule